// File: doc/BRIEF.md
# Split Read/Write DRAM Bank Mapper

This unit sits between a CPU's 16-bit address bus and a cartridge-style memory set: a 512 KB DRAM, a 32 KB BIOS ROM, and a 512 KB PPU pattern memory. Writes into a small I/O register window configure it. The DRAM appears to the CPU through one 32 KB window from 0x6000 to 0xDFFF. Reads and writes in that window are steered by two independent 4-bit bank registers. Loading the read bank switches the DRAM into read direction, and loading the write bank switches it into write direction, so only one direction is live at a time.

The unit also maps a 4 KB BIOS page at CPU 0xE000, maps an 8 KB bank of pattern memory at PPU 0x0000, and holds a 2-bit nametable mirroring code for the PPU side. The outputs are combinational from the current bus cycle and the registered configuration. No data passes through the unit: it only produces physical addresses and enables, so there is no valid/ready stream and no back-pressure. A register write changes the mapping from the following clock onward.

Top module: `dram_bank_mapper`

## Requirements
- R1: After reset, both DRAM bank registers, the BIOS page, the pattern bank and the mirroring code are 0. DRAM reads are enabled and DRAM writes are disabled.
- R2: A CPU write to address 0x4190 loads data bits [3:0] as the read bank, enables DRAM reads and disables DRAM writes.
- R3: A CPU write to address 0x4191 loads data bits [3:0] as the write bank, enables DRAM writes and disables DRAM reads.
- R4: A CPU access from 0x6000 to 0xDFFF inclusive is in the DRAM window. The DRAM address is {bank[3:0], (addr − 0x6000)[14:0]}. Addresses 0x5FFF and 0xE000 are outside the window.
- R5: While DRAM writes are disabled, a CPU write in the window leaves dram_wr_en low.
- R6: While DRAM reads are disabled, a CPU read in the window leaves dram_rd_en low and raises dflt_rd_en.
- R7: Window reads always use the read bank and window writes always use the write bank. Loading one bank leaves the other unchanged.
- R8: A CPU write to 0x4180 loads data bits [2:0] as the BIOS page. A CPU read from 0xE000 to 0xEFFF raises bios_en with bios_addr = {page[2:0], addr[11:0]}.
- R9: A CPU write to 0x4198 loads data bits [5:0] as the pattern bank. A PPU read with ppu_addr[13] = 0 raises ppu_mem_en with ppu_mem_addr = {bank[5:0], ppu_addr[12:0]}. A PPU read with ppu_addr[13] = 1 leaves ppu_mem_en low.
- R10: A CPU write to 0x418D loads data bits [1:0] into mirror_mode. The codes are 0 vertical, 1 horizontal, 2 single-screen low and 3 single-screen high.
- R11: Register decode compares all 16 address bits and acts only on cpu_wr. A write to an alias such as 0x5190, or a read of 0x4190, changes no mapping.
- R12: A register write takes effect on the clock edge that ends its bus cycle. Outputs during that same cycle still reflect the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | PPU address |
| ppu_rd | input | 1 | PPU read strobe |
| dram_addr | output | 19 | DRAM physical address |
| dram_rd_en | output | 1 | DRAM read enable |
| dram_wr_en | output | 1 | DRAM write enable |
| dflt_rd_en | output | 1 | Window read redirected to default memory |
| bios_addr | output | 15 | BIOS ROM physical address |
| bios_en | output | 1 | BIOS ROM read enable |
| ppu_mem_addr | output | 19 | Pattern memory physical address |
| ppu_mem_en | output | 1 | Pattern memory read enable |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
A wrong bank register shows up at once on the next window access, as the wrong upper four bits of dram_addr. A lost or stuck direction flag shows up as an enable that is missing or spurious: a write lands in DRAM when it should be dropped, or a read fails to fall through to default memory. These faults appear in the first cycle after the register write, so every setting is probed on the cycle right after it is loaded. The same-cycle probe catches a write that was wrongly made transparent. Window edges, decode aliases and cross-loading of the two banks are each stimulated, because a fault in any of them stays invisible until that exact access occurs.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  parameter int CPU_AW    = 16;
  parameter int CPU_DW    = 8;
  parameter int DBANK_W   = 4;
  parameter int WIN_OFF_W = 15;
  parameter int DRAM_AW   = DBANK_W + WIN_OFF_W;
  parameter int BPAGE_W   = 3;
  parameter int BPAGE_OFF = 12;
  parameter int BIOS_AW   = BPAGE_W + BPAGE_OFF;
  parameter int CBANK_W   = 6;
  parameter int PPU_AW    = 14;
  parameter int CBANK_OFF = 13;
  parameter int CHR_AW    = CBANK_W + CBANK_OFF;
  parameter int MIRR_W    = 2;

  parameter logic [CPU_AW-1:0] WIN_BASE  = 16'h6000;
  parameter logic [CPU_AW-1:0] BIOS_BASE = 16'hE000;

  parameter int REG_N = 5;
  typedef enum int {
    RI_RDBANK = 0,
    RI_WRBANK = 1,
    RI_BIOS   = 2,
    RI_CHR    = 3,
    RI_MIRR   = 4
  } reg_idx_e;

  parameter logic [CPU_AW-1:0] REG_ADDR [REG_N] = '{
    16'h4190, 16'h4191, 16'h4180, 16'h4198, 16'h418D
  };

  typedef enum logic [MIRR_W-1:0] {
    MIRR_VERT  = 2'd0,
    MIRR_HORZ  = 2'd1,
    MIRR_ONE_L = 2'd2,
    MIRR_ONE_H = 2'd3
  } mirr_e;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_wr,
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic [CPU_DW-1:0]    cpu_wdata,
  output logic [DBANK_W-1:0]   rd_bank,
  output logic [DBANK_W-1:0]   wr_bank,
  output logic                 rd_on,
  output logic                 wr_on,
  output logic [BPAGE_W-1:0]   bios_page,
  output logic [CBANK_W-1:0]   chr_bank,
  output mirr_e                mirror
);
  logic [REG_N-1:0] hit;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[CPU_DW-1:CBANK_W];

  for (genvar g = 0; g < REG_N; g++) begin : g_dec
    assign hit[g] = cpu_wr && (cpu_addr == REG_ADDR[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_bank   <= '0;
      wr_bank   <= '0;
      rd_on     <= 1'b1;
      wr_on     <= 1'b0;
      bios_page <= '0;
      chr_bank  <= '0;
      mirror    <= MIRR_VERT;
    end else begin
      if (hit[RI_RDBANK]) begin
        rd_bank <= cpu_wdata[DBANK_W-1:0];
        rd_on   <= 1'b1;
        wr_on   <= 1'b0;
      end
      if (hit[RI_WRBANK]) begin
        wr_bank <= cpu_wdata[DBANK_W-1:0];
        wr_on   <= 1'b1;
        rd_on   <= 1'b0;
      end
      if (hit[RI_BIOS]) bios_page <= cpu_wdata[BPAGE_W-1:0];
      if (hit[RI_CHR])  chr_bank  <= cpu_wdata[CBANK_W-1:0];
      if (hit[RI_MIRR]) mirror    <= mirr_e'(cpu_wdata[MIRR_W-1:0]);
    end
  end
endmodule

// File: rtl/mapper_cpu_dec.sv
module mapper_cpu_dec
  import mapper_pkg::*;
(
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic [DBANK_W-1:0]  rd_bank,
  input  logic [DBANK_W-1:0]  wr_bank,
  input  logic                rd_on,
  input  logic                wr_on,
  input  logic [BPAGE_W-1:0]  bios_page,
  output logic [DRAM_AW-1:0]  dram_addr,
  output logic                dram_rd_en,
  output logic                dram_wr_en,
  output logic                dflt_rd_en,
  output logic [BIOS_AW-1:0]  bios_addr,
  output logic                bios_en
);
  localparam logic [CPU_AW:0] WIN_END  = {1'b0, WIN_BASE} + (17'd1 << WIN_OFF_W);
  localparam logic [CPU_AW:0] BIOS_END = {1'b0, BIOS_BASE} + (17'd1 << BPAGE_OFF);

  logic                 in_win;
  logic                 in_bios;
  logic [WIN_OFF_W-1:0] win_off;
  logic [DBANK_W-1:0]   bank_sel;

  assign in_win  = (cpu_addr >= WIN_BASE) && ({1'b0, cpu_addr} < WIN_END);
  assign in_bios = (cpu_addr >= BIOS_BASE) && ({1'b0, cpu_addr} < BIOS_END);
  assign win_off = cpu_addr[WIN_OFF_W-1:0] - WIN_BASE[WIN_OFF_W-1:0];

  always_comb begin
    bank_sel = cpu_wr ? wr_bank : rd_bank;
    dram_addr  = {bank_sel, win_off};
    dram_rd_en = cpu_rd && in_win && rd_on;
    dram_wr_en = cpu_wr && in_win && wr_on;
    dflt_rd_en = cpu_rd && in_win && !rd_on;
    bios_en    = cpu_rd && in_bios;
    bios_addr  = {bios_page, cpu_addr[BPAGE_OFF-1:0]};
  end
endmodule

// File: rtl/mapper_ppu_map.sv
module mapper_ppu_map
  import mapper_pkg::*;
(
  input  logic [PPU_AW-1:0]  ppu_addr,
  input  logic               ppu_rd,
  input  logic [CBANK_W-1:0] chr_bank,
  input  mirr_e              mirror,
  output logic [CHR_AW-1:0]  ppu_mem_addr,
  output logic               ppu_mem_en,
  output logic [MIRR_W-1:0]  mirror_mode
);
  logic in_pat;

  assign in_pat       = (ppu_addr[PPU_AW-1:CBANK_OFF] == '0);
  assign ppu_mem_en   = ppu_rd && in_pat;
  assign ppu_mem_addr = {chr_bank, ppu_addr[CBANK_OFF-1:0]};
  assign mirror_mode  = mirror;
endmodule

// File: rtl/dram_bank_mapper.sv
module dram_bank_mapper
  import mapper_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [CPU_DW-1:0]  cpu_wdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [PPU_AW-1:0]  ppu_addr,
  input  logic               ppu_rd,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic               dram_rd_en,
  output logic               dram_wr_en,
  output logic               dflt_rd_en,
  output logic [BIOS_AW-1:0] bios_addr,
  output logic               bios_en,
  output logic [CHR_AW-1:0]  ppu_mem_addr,
  output logic               ppu_mem_en,
  output logic [MIRR_W-1:0]  mirror_mode
);
  logic [DBANK_W-1:0] rd_bank;
  logic [DBANK_W-1:0] wr_bank;
  logic               rd_on;
  logic               wr_on;
  logic [BPAGE_W-1:0] bios_page;
  logic [CBANK_W-1:0] chr_bank;
  mirr_e              mirror;

  mapper_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .rd_bank   (rd_bank),
    .wr_bank   (wr_bank),
    .rd_on     (rd_on),
    .wr_on     (wr_on),
    .bios_page (bios_page),
    .chr_bank  (chr_bank),
    .mirror    (mirror)
  );

  mapper_cpu_dec u_cpu (
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .rd_bank    (rd_bank),
    .wr_bank    (wr_bank),
    .rd_on      (rd_on),
    .wr_on      (wr_on),
    .bios_page  (bios_page),
    .dram_addr  (dram_addr),
    .dram_rd_en (dram_rd_en),
    .dram_wr_en (dram_wr_en),
    .dflt_rd_en (dflt_rd_en),
    .bios_addr  (bios_addr),
    .bios_en    (bios_en)
  );

  mapper_ppu_map u_ppu (
    .ppu_addr     (ppu_addr),
    .ppu_rd       (ppu_rd),
    .chr_bank     (chr_bank),
    .mirror       (mirror),
    .ppu_mem_addr (ppu_mem_addr),
    .ppu_mem_en   (ppu_mem_en),
    .mirror_mode  (mirror_mode)
  );
endmodule

// File: rtl/dram_bank_mapper_chk.sv
module dram_bank_mapper_chk
  import mapper_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic [CPU_DW-1:0]  cpu_wdata,
  input logic               cpu_rd,
  input logic               cpu_wr,
  input logic [PPU_AW-1:0]  ppu_addr,
  input logic               ppu_rd,
  input logic [DRAM_AW-1:0] dram_addr,
  input logic               dram_rd_en,
  input logic               dram_wr_en,
  input logic               dflt_rd_en,
  input logic [BIOS_AW-1:0] bios_addr,
  input logic               bios_en,
  input logic [CHR_AW-1:0]  ppu_mem_addr,
  input logic               ppu_mem_en,
  input logic [MIRR_W-1:0]  mirror_mode
);
  logic in_win;
  assign in_win = (cpu_addr >= 16'h6000) && (cpu_addr <= 16'hDFFF);

  // R2: next window read uses the just-loaded read bank
  assert_rdbank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == REG_ADDR[RI_RDBANK]) |=>
      (!(cpu_rd && !cpu_wr && in_win) ||
       (dram_rd_en && dram_addr[DRAM_AW-1:WIN_OFF_W] == $past(cpu_wdata[DBANK_W-1:0]))));

  // R3: next window write uses the just-loaded write bank
  assert_wrbank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == REG_ADDR[RI_WRBANK]) |=>
      (!(cpu_wr && in_win) ||
       (dram_wr_en && dram_addr[DRAM_AW-1:WIN_OFF_W] == $past(cpu_wdata[DBANK_W-1:0]))));

  // R5: after selecting read direction, window writes are dropped
  assert_wr_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == REG_ADDR[RI_RDBANK]) |=> !dram_wr_en);

  // R6: after selecting write direction, window reads fall through
  assert_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == REG_ADDR[RI_WRBANK]) |=>
      (!(cpu_rd && in_win) || (dflt_rd_en && !dram_rd_en)));

  // R7: the two DRAM directions are never enabled together
  assert_dir_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_rd_en && dram_wr_en));

  // R8: BIOS page follows the last 0x4180 write
  assert_bios_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == REG_ADDR[RI_BIOS]) |=>
      (!bios_en || bios_addr[BIOS_AW-1:BPAGE_OFF] == $past(cpu_wdata[BPAGE_W-1:0])));

  // R9: pattern bank follows the last 0x4198 write
  assert_chr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == REG_ADDR[RI_CHR]) |=>
      (!ppu_mem_en || ppu_mem_addr[CHR_AW-1:CBANK_OFF] == $past(cpu_wdata[CBANK_W-1:0])));

  // R9: upper PPU half never selects pattern memory
  assert_chr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_rd && ppu_addr[PPU_AW-1]) |-> !ppu_mem_en);

  // R10: mirroring code loaded from 0x418D
  assert_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == REG_ADDR[RI_MIRR]) |=> mirror_mode == $past(cpu_wdata[MIRR_W-1:0]));

  // R11 / R12: without a decoded write the mirroring code holds
  assert_mirror_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == REG_ADDR[RI_MIRR]) |=> $stable(mirror_mode));
endmodule

bind dram_bank_mapper dram_bank_mapper_chk u_chk (.*);

// File: tb/tb_dram_bank_mapper.sv
module tb_dram_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0;
  logic [18:0] dram_addr;
  logic        dram_rd_en, dram_wr_en, dflt_rd_en;
  logic [14:0] bios_addr;
  logic        bios_en;
  logic [18:0] ppu_mem_addr;
  logic        ppu_mem_en;
  logic [1:0]  mirror_mode;

  always #4 clk = ~clk;

  dram_bank_mapper dut (.*);

  typedef struct {
    string       tag;
    logic [18:0] d_addr;
    logic        rd_en, wr_en, dflt;
    logic [14:0] b_addr;
    logic        b_en;
    logic [18:0] p_addr;
    logic        p_en;
    logic [1:0]  mirr;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [3:0] m_rb = 0, m_wb = 0, m_pg = 0;
  logic [5:0] m_cb = 0;
  logic [1:0] m_mi = 0;
  logic       m_ron = 1, m_won = 0;

  task automatic op(input string tag, input logic rd, input logic wr,
                    input logic [15:0] a, input logic [7:0] d,
                    input logic prd, input logic [13:0] pa);
    exp_t e;
    logic win;
    @(posedge clk); #1;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    ppu_rd = prd; ppu_addr = pa;
    win = (a >= 16'h6000) && (a <= 16'hDFFF);
    e.tag    = tag;
    e.rd_en  = rd && win && m_ron;
    e.wr_en  = wr && win && m_won;
    e.dflt   = rd && win && !m_ron;
    e.d_addr = {(wr ? m_wb : m_rb), 15'(a - 16'h6000)};
    e.b_en   = rd && (a >= 16'hE000) && (a <= 16'hEFFF);
    e.b_addr = {m_pg[2:0], a[11:0]};
    e.p_en   = prd && !pa[13];
    e.p_addr = {m_cb, pa[12:0]};
    e.mirr   = m_mi;
    exp_q.push_back(e);
    if (wr) begin
      case (a)
        16'h4190: begin m_rb = d[3:0]; m_ron = 1; m_won = 0; end
        16'h4191: begin m_wb = d[3:0]; m_won = 1; m_ron = 0; end
        16'h4180: m_pg = {1'b0, d[2:0]};
        16'h4198: m_cb = d[5:0];
        16'h418D: m_mi = d[1:0];
        default: ;
      endcase
    end
  endtask

  // monitor: compare outputs mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        bad = (dram_rd_en !== e.rd_en) || (dram_wr_en !== e.wr_en) ||
              (dflt_rd_en !== e.dflt) || (bios_en !== e.b_en) ||
              (ppu_mem_en !== e.p_en) || (mirror_mode !== e.mirr) ||
              (ppu_mem_addr !== e.p_addr) ||
              ((e.rd_en || e.wr_en) && dram_addr !== e.d_addr) ||
              (e.b_en && bios_addr !== e.b_addr);
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: got rd=%b wr=%b dflt=%b da=%h ben=%b ba=%h pen=%b pa=%h mi=%0d exp rd=%b wr=%b dflt=%b da=%h ben=%b ba=%h pen=%b pa=%h mi=%0d",
                   e.tag, dram_rd_en, dram_wr_en, dflt_rd_en, dram_addr, bios_en,
                   bios_addr, ppu_mem_en, ppu_mem_addr, mirror_mode,
                   e.rd_en, e.wr_en, e.dflt, e.d_addr, e.b_en, e.b_addr,
                   e.p_en, e.p_addr, e.mirr);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    op("R1", 1, 0, 16'h6000, 8'h00, 1, 14'h0000);
    op("R1", 0, 1, 16'h6000, 8'h00, 0, 14'h0000);
    op("R1", 1, 0, 16'hE000, 8'h00, 0, 14'h0000);
    // R2 read bank, R4 window edges
    op("R2", 0, 1, 16'h4190, 8'hF5, 0, 14'h0000);
    op("R2", 1, 0, 16'h6000, 8'h00, 0, 14'h0000);
    op("R4", 1, 0, 16'hDFFF, 8'h00, 0, 14'h0000);
    op("R4", 1, 0, 16'h5FFF, 8'h00, 0, 14'h0000);
    op("R4", 1, 0, 16'hE000, 8'h00, 0, 14'h0000);
    op("R5", 0, 1, 16'h7000, 8'h11, 0, 14'h0000);
    // R3 write bank, R6 fall-through
    op("R3", 0, 1, 16'h4191, 8'h0A, 0, 14'h0000);
    op("R3", 0, 1, 16'h7123, 8'h55, 0, 14'h0000);
    op("R4", 0, 1, 16'hDFFF, 8'h55, 0, 14'h0000);
    op("R6", 1, 0, 16'h7123, 8'h00, 0, 14'h0000);
    // R7 independence of the two banks
    op("R7", 0, 1, 16'h4191, 8'h2C, 0, 14'h0000);
    op("R7", 0, 1, 16'h6000, 8'h00, 0, 14'h0000);
    op("R7", 0, 1, 16'h4190, 8'h03, 0, 14'h0000);
    op("R7", 1, 0, 16'h8421, 8'h00, 0, 14'h0000);
    op("R5", 0, 1, 16'h8421, 8'h77, 0, 14'h0000);
    // R8 BIOS page
    op("R8", 0, 1, 16'h4180, 8'hFE, 0, 14'h0000);
    op("R8", 1, 0, 16'hE345, 8'h00, 0, 14'h0000);
    op("R8", 1, 0, 16'hEFFF, 8'h00, 0, 14'h0000);
    op("R8", 1, 0, 16'hF000, 8'h00, 0, 14'h0000);
    // R9 pattern bank
    op("R9", 0, 1, 16'h4198, 8'hC7, 0, 14'h0000);
    op("R9", 0, 0, 16'h0000, 8'h00, 1, 14'h1ABC);
    op("R9", 0, 0, 16'h0000, 8'h00, 1, 14'h2000);
    // R10 mirroring codes, R12 same-cycle hold
    for (int m = 0; m < 4; m++) begin
      op("R12", 0, 1, 16'h418D, 8'(m + 8'hFC), 0, 14'h0000);
      op("R10", 0, 0, 16'h0000, 8'h00, 0, 14'h0000);
    end
    // R11 aliases and reads of register addresses
    op("R11", 0, 1, 16'h5190, 8'h09, 0, 14'h0000);
    op("R11", 1, 0, 16'h4191, 8'h00, 0, 14'h0000);
    op("R11", 0, 1, 16'h418C, 8'h01, 0, 14'h0000);
    op("R11", 1, 0, 16'h6010, 8'h00, 1, 14'h0010);
    op("R11", 0, 1, 16'h6010, 8'h00, 0, 14'h0000);
    @(posedge clk); #1;
    cpu_rd = 0; cpu_wr = 0; ppu_rd = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule